// File: doc/BRIEF.md
# Random-Backoff Channel Access Arbiter

This block decides when a half-duplex packet radio link may begin to transmit. It is evaluated once per periodic tick, normally every 10 ms. On that tick it looks at the carrier-detect input, a flag saying a frame is waiting, a flag saying the transmitter is idle, and the duplex mode. When access is granted it emits a single-cycle start-transmit pulse. Frame contents, keying of the transmitter and carrier detection are handled elsewhere.

In half-duplex mode the block waits for the channel to be clear. It counts down a slot counter while the channel is clear and reloads it whenever carrier is seen. When the counter runs out, it draws a byte from an internal pseudo-random generator and compares it with a persistence threshold. If the draw does not exceed the threshold, transmission starts. Otherwise the attempt waits for the next slot. In full-duplex mode the channel checks are skipped and transmission starts on the first qualifying tick. Slot time (in milliseconds) and persistence are written through a small configuration port.

Top module: `chan_access_arb`

## Requirements
- R1: A tick is evaluated only when `tx_idle_i` and `frame_pending_i` are both high. Any other tick gives no pulse and leaves the slot counter unchanged.
- R2: With `full_duplex_i` high, a qualifying tick always gives a start pulse, whatever the carrier and the slot counter. The counter is left unchanged.
- R3: In half-duplex mode, a qualifying tick with `carrier_i` high reloads the slot counter with slot_time/10 (integer division) and gives no pulse.
- R4: In half-duplex mode with carrier clear, a qualifying tick with the slot counter above 1 decrements the counter and gives no pulse. After a reload to N, the Nth such tick is the one that makes the attempt.
- R5: In half-duplex mode with carrier clear and the counter at 0 or 1, the counter is reloaded with slot_time/10. A byte is drawn, and if it is less than or equal to the persistence value a start pulse is given.
- R6: In the same case, a draw greater than the persistence value gives no pulse. The attempt is deferred to the next slot.
- R7: Synchronous reset sets persistence to 64, slot time to 100 (so the counter is 10) and `start_tx_o` low.
- R8: The draw is the low 8 bits of a 16-bit right-shifting Galois LFSR. Its next state is (s>>1) XOR (s[0] ? 16'hB400 : 0). Reset loads 16'hACE1. It advances on every clock edge outside reset and is never zero. The draw is the register value at the evaluating edge.
- R9: A cycle with `cfg_wr_i` high stores `cfg_slot_i` and `cfg_persist_i`. At the same edge it reloads the slot counter with `cfg_slot_i`/10. A tick in that same cycle is not evaluated and gives no pulse.
- R10: `start_tx_o` is registered. It is high only in the cycle after the evaluating tick edge and low in the cycle after that, unless another tick qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle arbitration tick (10 ms period) |
| carrier_i | input | 1 | Carrier detected on the channel |
| frame_pending_i | input | 1 | At least one frame is waiting |
| tx_idle_i | input | 1 | Transmitter is idle |
| full_duplex_i | input | 1 | Full-duplex mode, skip channel checks |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_slot_i | input | 10 | New slot time in ms |
| cfg_persist_i | input | 8 | New persistence threshold |
| start_tx_o | output | 1 | One-cycle start-transmit pulse |

## Verification
The bench tracks the slot count and the generator state in its own model. It goes after the exact tick on which an attempt happens after a reload. An off-by-one in the decrement-then-test order would show up as a pulse one tick early or late. It checks that carrier in the middle of a countdown restarts the full slot, and that full duplex grants even while carrier is present. It checks the threshold edges: persistence 255 must always grant, persistence 0 grants only on a zero draw, and a comparison that is inverted or strict would miss grants. It also checks that a configuration write takes effect at once and suppresses a tick in the same cycle, and that ticks without a pending frame or an idle transmitter leave the countdown where it was.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // Galois right-shift step for a pseudo-random state register
  function automatic logic [15:0] lfsr16_step(input logic [15:0] s, input logic [15:0] taps);
    lfsr16_step = (s >> 1) ^ (s[0] ? taps : 16'h0000);
  endfunction
endpackage

// File: rtl/arb_lfsr.sv
module arb_lfsr #(
  parameter int          DRAW_W = 8,
  parameter logic [15:0] TAPS   = 16'hB400,
  parameter logic [15:0] SEED   = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DRAW_W-1:0] draw_o
);
  import arb_pkg::*;

  logic [15:0] state_q;

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else     state_q <= lfsr16_step(state_q, TAPS);
  end

  assign draw_o = state_q[DRAW_W-1:0];

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst)
    state_q != 16'h0000); // R8

  AST_LFSR_MOVES: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> state_q != $past(state_q)); // R8
endmodule

// File: rtl/arb_slot_ctr.sv
module arb_slot_ctr #(
  parameter int               CNT_W   = 10,
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= RST_VAL;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  AST_LOAD_DEC_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(load_i && dec_i)); // R4

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    dec_i |-> cnt_q > CNT_W'(1)); // R4
endmodule

// File: rtl/chan_access_arb.sv
module chan_access_arb #(
  parameter int          SLOT_W    = 10,
  parameter int          PERS_W    = 8,
  parameter int          TICK_DIV  = 10,
  parameter int          DEF_SLOT  = 100,
  parameter int          DEF_PERS  = 64,
  parameter logic [15:0] LFSR_TAPS = 16'hB400,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              carrier_i,
  input  logic              frame_pending_i,
  input  logic              tx_idle_i,
  input  logic              full_duplex_i,
  input  logic              cfg_wr_i,
  input  logic [SLOT_W-1:0] cfg_slot_i,
  input  logic [PERS_W-1:0] cfg_persist_i,
  output logic              start_tx_o
);
  localparam logic [SLOT_W-1:0] DIV_V    = SLOT_W'(TICK_DIV);
  localparam logic [SLOT_W-1:0] RST_CNT  = SLOT_W'(DEF_SLOT / TICK_DIV);
  localparam logic [SLOT_W-1:0] RST_SLOT = SLOT_W'(DEF_SLOT);
  localparam logic [PERS_W-1:0] RST_PERS = PERS_W'(DEF_PERS);

  logic [SLOT_W-1:0] slot_q;
  logic [PERS_W-1:0] pers_q;
  logic [SLOT_W-1:0] slot_cnt;
  logic [SLOT_W-1:0] reload_val;
  logic [PERS_W-1:0] draw;
  logic              eval, half_eval, expired, cnt_load, cnt_dec, grant;
  logic              start_q;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= RST_SLOT;
      pers_q <= RST_PERS;
    end else if (cfg_wr_i) begin
      slot_q <= cfg_slot_i;
      pers_q <= cfg_persist_i;
    end
  end

  arb_lfsr #(.DRAW_W(PERS_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst(rst), .draw_o(draw)
  );

  // arbitration decision for this tick
  always_comb begin
    reload_val = cfg_wr_i ? (cfg_slot_i / DIV_V) : (slot_q / DIV_V);
    eval       = tick_i && tx_idle_i && frame_pending_i && !cfg_wr_i;
    half_eval  = eval && !full_duplex_i;
    expired    = slot_cnt <= SLOT_W'(1);
    cnt_load   = cfg_wr_i || (half_eval && (carrier_i || expired));
    cnt_dec    = half_eval && !carrier_i && !expired;
    grant      = (eval && full_duplex_i) ||
                 (half_eval && !carrier_i && expired && (draw <= pers_q));
  end

  arb_slot_ctr #(.CNT_W(SLOT_W), .RST_VAL(RST_CNT)) u_slot (
    .clk(clk), .rst(rst), .load_i(cnt_load), .load_val_i(reload_val),
    .dec_i(cnt_dec), .cnt_o(slot_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) start_q <= 1'b0;
    else     start_q <= grant;
  end

  assign start_tx_o = start_q;

  AST_PULSE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    start_tx_o |-> $past(tick_i && tx_idle_i && frame_pending_i && !cfg_wr_i)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!(tick_i && tx_idle_i && frame_pending_i) && !cfg_wr_i) |=> $stable(slot_cnt)); // R1

  AST_DUPLEX_GRANT: assert property (@(posedge clk) disable iff (rst)
    (tick_i && tx_idle_i && frame_pending_i && full_duplex_i && !cfg_wr_i)
      |=> (start_tx_o && $stable(slot_cnt))); // R2

  AST_CARRIER_DEFER: assert property (@(posedge clk) disable iff (rst)
    (tick_i && tx_idle_i && frame_pending_i && carrier_i && !full_duplex_i && !cfg_wr_i)
      |=> (!start_tx_o && slot_cnt == slot_q / DIV_V)); // R3

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (tick_i && tx_idle_i && frame_pending_i && !carrier_i && !full_duplex_i &&
     !cfg_wr_i && slot_cnt > SLOT_W'(1))
      |=> (!start_tx_o && slot_cnt == $past(slot_cnt) - SLOT_W'(1))); // R4

  AST_CFG_RELOAD: assert property (@(posedge clk) disable iff (rst)
    cfg_wr_i |=> (!start_tx_o && slot_cnt == $past(cfg_slot_i) / DIV_V)); // R9
endmodule

// File: tb/chan_access_arb_test.sv
module chan_access_arb_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0, carrier_i = 1'b0, frame_pending_i = 1'b0;
  logic       tx_idle_i = 1'b0, full_duplex_i = 1'b0, cfg_wr_i = 1'b0;
  logic [9:0] cfg_slot_i = '0;
  logic [7:0] cfg_persist_i = '0;
  logic       start_tx_o;

  always #2 clk = ~clk; // 250 MHz

  chan_access_arb uut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .carrier_i(carrier_i),
    .frame_pending_i(frame_pending_i), .tx_idle_i(tx_idle_i),
    .full_duplex_i(full_duplex_i), .cfg_wr_i(cfg_wr_i),
    .cfg_slot_i(cfg_slot_i), .cfg_persist_i(cfg_persist_i),
    .start_tx_o(start_tx_o)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  bit    exp_q[$];
  string tag_q[$];
  event  sample_ev;

  // bench model of configuration, countdown and generator (from R3..R9)
  int          m_slot, m_pers, m_cnt;
  logic [15:0] m_lfsr;

  always @(posedge clk) begin
    if (rst) m_lfsr <= 16'hACE1;
    else     m_lfsr <= (m_lfsr >> 1) ^ (m_lfsr[0] ? 16'hB400 : 16'h0000);
  end

  task automatic check(input string tag, input bit act, input bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: start_tx_o=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int slot, input int pers);
    @(negedge clk);
    cfg_wr_i = 1'b1; cfg_slot_i = 10'(slot); cfg_persist_i = 8'(pers);
    m_slot = slot; m_pers = pers; m_cnt = slot / 10;
    @(negedge clk);
    cfg_wr_i = 1'b0;
  endtask

  // driver: one tick, expectation pushed for the monitor
  task automatic do_tick(input bit idle, input bit pend, input bit car, input bit dup,
                         input bit wr, input int nslot, input int npers, input string ftag);
    bit    e;
    string t;
    @(negedge clk);
    tx_idle_i = idle; frame_pending_i = pend; carrier_i = car; full_duplex_i = dup;
    cfg_wr_i = wr; cfg_slot_i = 10'(nslot); cfg_persist_i = 8'(npers);
    tick_i = 1'b1;
    e = 1'b0;
    if (wr) begin
      m_slot = nslot; m_pers = npers; m_cnt = nslot / 10; t = "R9";
    end else if (!(idle && pend)) begin
      t = "R1";
    end else if (dup) begin
      e = 1'b1; t = "R2";
    end else if (car) begin
      m_cnt = m_slot / 10; t = "R3";
    end else if (m_cnt > 1) begin
      m_cnt--; t = "R4";
    end else begin
      m_cnt = m_slot / 10;
      e = (int'(m_lfsr[7:0]) <= m_pers);
      t = e ? "R5" : "R6";
    end
    if (ftag != "") t = ftag;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    tick_i = 1'b0; cfg_wr_i = 1'b0;
    -> sample_ev;
    repeat (2) @(negedge clk);
  endtask

  task automatic plain_tick(input bit car, input bit dup, input string ftag);
    do_tick(1'b1, 1'b1, car, dup, 1'b0, 0, 0, ftag);
  endtask

  // monitor: pops expectations as results appear
  initial begin
    forever begin
      bit    e;
      string t;
      @(sample_ev);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, start_tx_o, e);
      if (e) begin
        @(negedge clk);
        check("R10", start_tx_o, 1'b0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_slot = 100; m_pers = 64; m_cnt = 10;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R7", start_tx_o, 1'b0);

    // R7: default slot 100 gives a countdown of 10 ticks, default persistence 64
    for (int i = 0; i < 10; i++) plain_tick(1'b0, 1'b0, "R7");
    for (int i = 0; i < 20; i++) plain_tick(1'b0, 1'b0, "");

    // R1: unqualified ticks do nothing and keep the count
    cfg_write(30, 255);
    plain_tick(1'b0, 1'b0, "R4");
    do_tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, "R1");
    do_tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0, "R1");
    do_tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 0, 0, "R1");
    plain_tick(1'b0, 1'b0, "R4");
    plain_tick(1'b0, 1'b0, "R5");

    // R3: carrier mid-countdown restarts the slot
    plain_tick(1'b0, 1'b0, "R4");
    plain_tick(1'b1, 1'b0, "R3");
    plain_tick(1'b0, 1'b0, "R4");
    plain_tick(1'b0, 1'b0, "R4");
    plain_tick(1'b0, 1'b0, "R5");

    // R2: full duplex grants through carrier and leaves the count
    plain_tick(1'b1, 1'b1, "R2");
    plain_tick(1'b0, 1'b1, "R2");
    plain_tick(1'b0, 1'b0, "R4");
    plain_tick(1'b0, 1'b0, "R4");
    plain_tick(1'b0, 1'b0, "R5");

    // R6: persistence 0 grants only on a zero draw
    cfg_write(5, 0);
    for (int i = 0; i < 16; i++) plain_tick(1'b0, 1'b0, "");

    // R8: draws compared against mid-range threshold every tick
    cfg_write(0, 127);
    for (int i = 0; i < 24; i++) plain_tick(1'b0, 1'b0, "R8");

    // R9: write in the same cycle as a tick wins and reloads
    do_tick(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 40, 255, "R9");
    plain_tick(1'b0, 1'b0, "R9");
    plain_tick(1'b0, 1'b0, "R9");
    plain_tick(1'b0, 1'b0, "R9");
    plain_tick(1'b0, 1'b0, "R9");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule